// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A 4-bit synchronous counter written as an explicit state machine in which each state stands for one count value. A direction input chooses whether an enabled step adds or subtracts one. A parallel load input writes the count from a data input.

The block is one stage of a wider counter. Each stage takes a carry-in from the stage below and drives a single carry/borrow output to the stage above. In up mode that output acts as a ripple carry and in down mode as a borrow. Because it is gated by the incoming carry, identical stages chain into wider up/down counters with no extra logic.

The reset is active low and synchronous. The count output is decoded from the present state alone. The carry/borrow output is combinational in the present state, the carry-in and the direction, and has no register.

Top module: `updn_counter`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the count becomes 0000 at that edge. Reset takes priority over load and counting.
- R2: With reset inactive and `load_i` high at a rising edge, the count takes the value of `load_val_i`, whatever the enable, carry-in and direction inputs are.
- R3: With `load_i` low, the count changes only when `cnt_en_i` and `carry_i` are both high. Otherwise it holds its value.
- R4: An enabled step with `down_i` low adds one to the count, and 1111 wraps to 0000.
- R5: An enabled step with `down_i` high subtracts one from the count, and 0000 wraps to 1111.
- R6: With `down_i` low, `carry_o` is high exactly when the count is 1111 and `carry_i` is high.
- R7: With `down_i` high, `carry_o` is high exactly when the count is 0000 and `carry_i` is high. It stays low at 1111 in down mode and at 0000 in up mode.
- R8: `carry_o` does not depend on `cnt_en_i`, and it follows changes of `carry_i` and `down_i` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Parallel load request |
| load_val_i | input | 4 | Value written by a load |
| cnt_en_i | input | 1 | Count enable |
| carry_i | input | 1 | Carry/borrow from the lower stage |
| down_i | input | 1 | 1 = decrement, 0 = increment |
| count_o | output | 4 | Present count |
| carry_o | output | 1 | Carry (up) or borrow (down) to the upper stage |

## Verification
The case that is hardest to reach is the carry/borrow output at the two wrap points when the enable is low. The counter has to be parked at 1111 or 0000 first. From there the bench leaves the enable low and toggles the carry-in and the direction, so the output is seen reacting to them without the count moving. The bench reaches those states through loads and through full sweeps in both directions, so every wrap is also seen on a real enabled step.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_next_state.sv
module updn_next_state #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_i,
  input  updn_pkg::dir_e   dir_i,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // load wins; every path assigns next_o
  always_comb begin
    next_o = state_i;
    if (load_i) begin
      next_o = load_val_i;
    end else if (step_i) begin
      unique case (dir_i)
        updn_pkg::DIR_UP:   next_o = state_i + ONE;
        updn_pkg::DIR_DOWN: next_o = state_i - ONE;
        default:            next_o = state_i;
      endcase
    end
  end
endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  // synchronous reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_o <= ZERO;
    else         state_o <= next_i;
  end
endmodule

// File: rtl/updn_carry_gen.sv
module updn_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             carry_i,
  input  updn_pkg::dir_e   dir_i,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_top, at_bot;
  assign at_top = (state_i == TOP);
  assign at_bot = (state_i == BOT);

  always_comb begin
    carry_o = 1'b0;
    if (carry_i) begin
      unique case (dir_i)
        updn_pkg::DIR_UP:   carry_o = at_top;
        updn_pkg::DIR_DOWN: carry_o = at_bot;
        default:            carry_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             cnt_en_i,
  input  logic             carry_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] state_q, state_d;
  logic             step;
  updn_pkg::dir_e   dir;

  assign step = cnt_en_i & carry_i;
  assign dir  = down_i ? updn_pkg::DIR_DOWN : updn_pkg::DIR_UP;

  updn_next_state #(.WIDTH(WIDTH)) u_next (
    .state_i   (state_q),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .step_i    (step),
    .dir_i     (dir),
    .next_o    (state_d)
  );

  updn_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .next_i (state_d),
    .state_o(state_q)
  );

  updn_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .state_i(state_q),
    .carry_i(carry_i),
    .dir_i  (dir),
    .carry_o(carry_o)
  );

  assign count_o = state_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic             cnt_en_i,
  input logic             carry_i,
  input logic             down_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |=> count_o == BOT);

  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(cnt_en_i && carry_i)) |=> $stable(count_o));

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && carry_i && !down_i) |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R5
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && carry_i && down_i) |=> count_o == WIDTH'($past(count_o) - 1'b1));

  // R6
  up_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i && !down_i && count_o == TOP) |-> carry_o);

  // R7
  down_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i && down_i && count_o == BOT) |-> carry_o);

  // R7
  wrong_end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((down_i && count_o == TOP) || (!down_i && count_o == BOT)) |-> !carry_o);

  // R8
  carry_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> carry_i);
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .cnt_en_i  (cnt_en_i),
  .carry_i   (carry_i),
  .down_i    (down_i),
  .count_o   (count_o),
  .carry_o   (carry_o)
);

// File: tb/tb_updn_counter.sv
`timescale 1ns/1ps
module tb_updn_counter;
  localparam int WIDTH = 4;
  localparam int NVEC  = 17;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_i = 1'b0;
  logic [WIDTH-1:0] load_val_i = '0;
  logic             cnt_en_i = 1'b0;
  logic             carry_i = 1'b0;
  logic             down_i = 1'b0;
  logic [WIDTH-1:0] count_o;
  logic             carry_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  updn_counter #(.WIDTH(WIDTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_val_i(load_val_i),
    .cnt_en_i(cnt_en_i), .carry_i(carry_i), .down_i(down_i),
    .count_o(count_o), .carry_o(carry_o)
  );

  // {rst_n, load, val[3:0], en, ci, down, exp_count[3:0], exp_carry}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R1 reset
    {1'b1, 1'b1, 4'd14, 1'b1, 1'b1, 1'b0, 4'd14, 1'b0}, // R2 load
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 4'd15, 1'b1}, // R4 R6
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 4'd0,  1'b0}, // R4 wrap, R7 low at 0 up
    {1'b1, 1'b1, 4'd1,  1'b1, 1'b1, 1'b1, 4'd1,  1'b0}, // R2
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'd0,  1'b1}, // R5 R7
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'd15, 1'b0}, // R5 wrap, R7 low at 15 down
    {1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd15, 1'b0}, // R3 hold
    {1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd15, 1'b1}, // R8 carry with en low
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd15, 1'b0}, // R3 no ci
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd0,  1'b0}, // R2
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 4'd0,  1'b0}, // R3
    {1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd0,  1'b1}, // R8 borrow with en low
    {1'b0, 1'b1, 4'd9,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R1 over load
    {1'b1, 1'b1, 4'd7,  1'b1, 1'b1, 1'b1, 4'd7,  1'b0}, // R2 over count
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'd6,  1'b0}, // R5
    {1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 4'd7,  1'b0}  // R4
  };

  function automatic string vec_req(int i);
    case (i)
      0, 13:          return "R1";
      1, 4, 10, 14:   return "R2";
      7, 9, 11:       return "R3";
      2, 3, 16:       return "R4";
      5, 6, 15:       return "R5";
      8, 12:          return "R8";
      default:        return "R6";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit r, bit ld, logic [3:0] v, bit en, bit ci, bit dn);
    rst_ni = r; load_i = ld; load_val_i = v; cnt_en_i = en; carry_i = ci; down_i = dn;
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    step();
    check("R1", count_o, 0);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      drive(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      step();
      check(vec_req(i), count_o, VEC[i][4:1]);
      check(vec_req(i), carry_o, VEC[i][0]);
    end

    // R4 R6 full up sweep from 0
    @(negedge clk_i); drive(1, 1, 4'd0, 0, 0, 0); step();
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk_i); drive(1, 0, 4'd0, 1, 1, 0); step();
      check("R4", count_o, k % 16);
      check("R6", carry_o, (k % 16) == 15);
    end

    // R5 R7 full down sweep from 0
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk_i); drive(1, 0, 4'd0, 1, 1, 1); step();
      check("R5", count_o, (16 - k) % 16);
      check("R7", carry_o, ((16 - k) % 16) == 0);
    end

    // R8 combinational response without a clock edge
    @(negedge clk_i); drive(1, 1, 4'd15, 0, 0, 0); step();
    @(negedge clk_i); drive(1, 0, 4'd0, 0, 0, 0); #1;
    check("R8", carry_o, 0);
    carry_i = 1'b1; #1;
    check("R8", carry_o, 1);
    down_i = 1'b1; #1;
    check("R8", carry_o, 0);
    cnt_en_i = 1'b1; carry_i = 1'b0; #1;
    check("R8", carry_o, 0);
    cnt_en_i = 1'b0; step();
    check("R3", count_o, 15);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule